// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two eight-bit ports, A and B, and keeps one holding register for each direction of transfer. A holding register takes a copy of its source port whenever its own capture strobe rises. The strobes arrive from outside the system clock domain, so they are synchronized and edge-detected on `clk` before they load anything. Each port is presented as separate input, output and output-enable signals, so the tri-state pads stay outside the block.

A single isolate control turns both ports into inputs. When isolate is low, a direction control picks the one port that is driven. Each direction has a select that chooses between live data from the opposite port, which is passed through with no register in the path, and the value held in that direction's register. Capture never stops: the holding registers keep loading on strobe edges whether the ports are isolated, driven or turned the other way.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a rising edge of `cap_ab`, the A-to-B register loads `a_in` as it stands at the (SYNC_STAGES+1)-th rising `clk` edge after the strobe is first seen high. `a_in` must stay stable over that span.
- R2: On a rising edge of `cap_ba`, the B-to-A register loads `b_in` with the same timing as R1.
- R3: A strobe that stays high produces exactly one load. Data that changes while the strobe is held high is not captured.
- R4: Loads happen whatever the values of `iso`, `to_b`, `sel_ab_held` and `sel_ba_held`.
- R5: With `iso`=1, both `a_oe` and `b_oe` are 0. Both registers can still load, including on the same cycle.
- R6: With `iso`=0 and `to_b`=0, `a_oe`=1 and `b_oe`=0. If `sel_ba_held`=0, `a_out` equals `b_in` in the same cycle. If `sel_ba_held`=1, `a_out` equals the B-to-A register.
- R7: With `iso`=0 and `to_b`=1, `b_oe`=1 and `a_oe`=0. If `sel_ab_held`=0, `b_out` equals `a_in` in the same cycle. If `sel_ab_held`=1, `b_out` equals the A-to-B register.
- R8: `a_oe` and `b_oe` are never 1 together.
- R9: The select of the direction that is not enabled has no effect on either enable or on the driven port's data.
- R10: While the synchronous active-high `rst` is 1, both enables are 0. After reset, both holding registers read 0x00.
- R11: All eight bit lanes behave the same and share the controls. Patterns with mixed bits pass through unchanged, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| iso | input | 1 | 1 = both ports are inputs |
| to_b | input | 1 | 0 = drive A, 1 = drive B (when `iso`=0) |
| sel_ab_held | input | 1 | B output source: 0 = live A, 1 = A-to-B register |
| sel_ba_held | input | 1 | A output source: 0 = live B, 1 = B-to-A register |
| cap_ab | input | 1 | Capture strobe for the A-to-B register, asynchronous |
| cap_ba | input | 1 | Capture strobe for the B-to-A register, asynchronous |
| a_in | input | W | Value seen on the A pads |
| a_out | output | W | Value to drive on the A pads |
| a_oe | output | 1 | A pad drive enable |
| b_in | input | W | Value seen on the B pads |
| b_out | output | W | Value to drive on the B pads |
| b_oe | output | 1 | B pad drive enable |

## Verification
A holding register with a wrong value stays hidden until its direction is enabled with the held select. The bench therefore reads each register back through the driven port, in the same cycle the controls change, after every load. A faulty strobe path shows up as a missing capture, a late capture or a double capture. A late capture lands after the SYNC_STAGES+1 window. A double capture swaps in data that changed while the strobe was held. Enable faults show at the ports at once, with no latency, because the enables and the live path are combinational from the controls.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef struct packed {
    logic iso;
    logic to_b;
    logic ab_held;
    logic ba_held;
  } bxr_ctrl_t;
endpackage

// File: rtl/bxr_strobe_sync.sv
module bxr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bxr_hold_reg.sv
module bxr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bxr_lane_mux.sv
module bxr_lane_mux
  import bxr_pkg::*;
#(
  parameter int W = 8
) (
  input  bxr_ctrl_t    ctrl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] ab_q,
  input  logic [W-1:0] ba_q,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign b_out[i] = ctrl.ab_held ? ab_q[i] : a_in[i];
    assign a_out[i] = ctrl.ba_held ? ba_q[i] : b_in[i];
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         iso,
  input  logic         to_b,
  input  logic         sel_ab_held,
  input  logic         sel_ba_held,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  bxr_ctrl_t    ctrl;
  logic         ld_ab, ld_ba;
  logic [W-1:0] ab_q, ba_q;

  assign ctrl = '{iso: iso, to_b: to_b, ab_held: sel_ab_held, ba_held: sel_ba_held};

  bxr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk(clk), .rst(rst), .strobe_i(cap_ab), .pulse_o(ld_ab));
  bxr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk(clk), .rst(rst), .strobe_i(cap_ba), .pulse_o(ld_ba));

  bxr_hold_reg #(.W(W)) u_reg_ab (
    .clk(clk), .rst(rst), .load(ld_ab), .d(a_in), .q(ab_q));
  bxr_hold_reg #(.W(W)) u_reg_ba (
    .clk(clk), .rst(rst), .load(ld_ba), .d(b_in), .q(ba_q));

  bxr_lane_mux #(.W(W)) u_mux (
    .ctrl(ctrl), .a_in(a_in), .b_in(b_in), .ab_q(ab_q), .ba_q(ba_q),
    .a_out(a_out), .b_out(b_out));

  assign a_oe = ~rst & ~ctrl.iso & ~ctrl.to_b;
  assign b_oe = ~rst & ~ctrl.iso &  ctrl.to_b;
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         iso,
  input logic         to_b,
  input logic         sel_ab_held,
  input logic         sel_ba_held,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  a_r8_one_driver: assert property (@(posedge clk) !(a_oe && b_oe));

  a_r5_isolate: assert property (@(posedge clk) disable iff (rst)
    iso |-> (!a_oe && !b_oe));

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |-> (!a_oe && !b_oe));

  a_r6_live_to_a: assert property (@(posedge clk) disable iff (rst)
    (!iso && !to_b && !sel_ba_held) |-> (a_oe && a_out == b_in));

  a_r7_live_to_b: assert property (@(posedge clk) disable iff (rst)
    (!iso && to_b && !sel_ab_held) |-> (b_oe && b_out == a_in));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .iso(iso), .to_b(to_b),
  .sel_ab_held(sel_ab_held), .sel_ba_held(sel_ba_held),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int W = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iso = 1'b1, to_b = 1'b0, sel_ab_held = 1'b0, sel_ba_held = 1'b0;
  logic cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.W(W), .SYNC_STAGES(2)) u_bus_xcvr_reg (
    .clk(clk), .rst(rst), .iso(iso), .to_b(to_b),
    .sel_ab_held(sel_ab_held), .sel_ba_held(sel_ba_held),
    .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  // {iso,to_b,sel_ab,sel_ba}, a_in, b_in, {a_oe,b_oe}, driven data
  // Registers hold AB=3C, BA=A5 while the table runs.
  localparam logic [29:0] VEC [NV] = '{
    {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00},
    {4'b1111, 8'h11, 8'h22, 2'b00, 8'h00},
    {4'b0000, 8'h11, 8'h22, 2'b10, 8'h22},
    {4'b0010, 8'h11, 8'h66, 2'b10, 8'h66},
    {4'b0001, 8'h11, 8'h22, 2'b10, 8'hA5},
    {4'b0011, 8'h99, 8'h5A, 2'b10, 8'hA5},
    {4'b0100, 8'h77, 8'h22, 2'b01, 8'h77},
    {4'b0101, 8'hC3, 8'h22, 2'b01, 8'hC3},
    {4'b0110, 8'h77, 8'h22, 2'b01, 8'h3C},
    {4'b0111, 8'h0F, 8'hF0, 2'b01, 8'h3C}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic i, input logic d, input logic sab, input logic sba);
    iso = i; to_b = d; sel_ab_held = sab; sel_ba_held = sba;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // read held registers back through the ports
  task automatic read_ab(input string tag, input logic [W-1:0] exp);
    ctl(1'b0, 1'b1, 1'b1, 1'b0); #1;
    check(tag, b_out, exp);
  endtask
  task automatic read_ba(input string tag, input logic [W-1:0] exp);
    ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
    check(tag, a_out, exp);
  endtask

  task automatic pulse(input logic do_ab, input logic do_ba);
    cap_ab = do_ab; cap_ba = do_ba;
    tick(4);
    cap_ab = 1'b0; cap_ba = 1'b0;
    tick(2);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= 20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    tick(3);
    // R10: enables low while in reset even with a drive request
    ctl(1'b0, 1'b0, 1'b0, 1'b0); #1;
    check("R10 a_oe in reset", {7'd0, a_oe}, 8'd0);
    ctl(1'b0, 1'b1, 1'b0, 1'b0); #1;
    check("R10 b_oe in reset", {7'd0, b_oe}, 8'd0);
    tick(1);
    rst = 1'b0;
    tick(1);
    read_ab("R10 AB cleared", 8'h00);
    read_ba("R10 BA cleared", 8'h00);

    // R1/R2/R4: load both while isolated
    ctl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'h3C; b_in = 8'hA5;
    pulse(1'b1, 1'b1);                // R5 same-cycle captures
    a_in = 8'h00; b_in = 8'h00;
    read_ab("R1 R5 AB load", 8'h3C);
    read_ba("R2 R5 BA load", 8'hA5);

    // table: R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      {iso, to_b, sel_ab_held, sel_ba_held} = VEC[v][29:26];
      a_in = VEC[v][25:18];
      b_in = VEC[v][17:10];
      #1;
      check($sformatf("R8 R5 enables v%0d", v), {6'd0, a_oe, b_oe}, {6'd0, VEC[v][9:8]});
      if (VEC[v][9]) check($sformatf("R6 R9 a_out v%0d", v), a_out, VEC[v][7:0]);
      if (VEC[v][8]) check($sformatf("R7 R9 R11 b_out v%0d", v), b_out, VEC[v][7:0]);
      tick(1);
    end

    // R4: capture while driving the other way, held select on
    ctl(1'b0, 1'b0, 1'b1, 1'b1);
    a_in = 8'h81; b_in = 8'h42;
    pulse(1'b1, 1'b0);
    read_ab("R4 AB while A driven", 8'h81);
    read_ba("R4 BA untouched", 8'hA5);

    // R3: held strobe captures once
    ctl(1'b1, 1'b0, 1'b0, 1'b0);
    b_in = 8'h5E;
    cap_ba = 1'b1;
    tick(4);
    b_in = 8'hE7;
    tick(5);
    cap_ba = 1'b0;
    tick(3);
    read_ba("R3 single capture", 8'h5E);

    // R10: reset mid-run clears registers
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    tick(1);
    read_ab("R10 AB after rerst", 8'h00);
    read_ba("R10 BA after rerst", 8'h00);

    finish_run();
  end
endmodule